// File: doc/BRIEF.md
# Transmit Completion Status Stack

This block keeps a short first-in, first-out record of how each transmitted frame ended. Each time the transmit engine finishes a frame it raises a push strobe together with four flags: a success-interrupt request, a jabber error, an underrun and an excessive-collision abort. The block turns these into a status byte. The host sees the oldest byte on a byte-wide read port, and any host write to that port discards the oldest entry so the next one moves up.

The stack holds four entries by default. When a frame completes while the stack is full, the frame gets no new entry. Instead the newest held entry is marked as overflowed. A jabber or underrun latches a stall toward the transmitter, and only the transmit-reset input releases it. The same reset also empties the stack. A completion event goes to the interrupt unit while the presented entry asks for attention.

Top module: `txs_stack`

## Requirements
- R1: After reset the read port is 8'h00, the completion event is low and the stall is low.
- R2: A push makes an entry that reads as bit 7 = 1 (valid), bit 6 = success-interrupt request, bit 5 = jabber, bit 4 = underrun, bit 3 = excessive collisions, bit 2 = 0 and bits 1:0 = 0. The entry is visible on the port in the cycle after the push edge if the stack was empty.
- R3: Entries are presented oldest first. A host write in a cycle where the stack holds at least one entry removes the presented entry at that clock edge.
- R4: With the stack empty the port reads 8'h00. A host write to an empty stack changes nothing.
- R5: A push while DEPTH entries are held, with no pop in the same cycle, stores nothing new. It sets bit 2 of the most recently stored entry instead, and that bit shows when the entry reaches the port.
- R6: A push with jabber or underrun set raises the stall output in the next cycle. The stall then stays high until a transmit reset.
- R7: A transmit reset empties the stack and lowers the stall in the next cycle. Any push or host write in the same cycle is discarded.
- R8: The completion event is high exactly when the port shows a valid entry with any of bits 6 down to 2 set.
- R9: A push and a host write in the same cycle both take effect. On a full stack this stores the new entry without marking overflow. On an empty stack the write is ignored and the push is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fin_push_i | input | 1 | Frame-finished strobe from the transmitter |
| fin_irq_req_i | input | 1 | Success interrupt was requested for the frame |
| fin_jabber_i | input | 1 | Frame ended with a jabber error |
| fin_underrun_i | input | 1 | Frame ended with an underrun |
| fin_maxcoll_i | input | 1 | Frame aborted after the collision limit |
| host_wr_i | input | 1 | Host write strobe to the status port (pops) |
| host_rd_data_o | output | 8 | Oldest status byte, zero when empty |
| txdone_evt_o | output | 1 | Completion event to the interrupt unit |
| tx_reset_i | input | 1 | Transmit reset: empties stack, releases stall |
| tx_stall_o | output | 1 | Transmission held until transmit reset |

## Verification
A frame completion and a host pop can arrive in the same cycle. This matters most when the stack is full, where the pop has to make room before the push decides between storing and marking overflow. It also matters when the stack is empty, where the pop must be ignored. The bench fills the stack to its depth, then drives the push and write strobes on one clock edge. The scoreboard model applies the pop first and then the push, and every entry drained afterward is compared, with the overflow bit included. The same pairing of a push with a transmit reset checks that the reset wins.

// File: rtl/txs_pkg.sv
package txs_pkg;

  // Bit positions of the presented status byte (host software decodes these)
  localparam int unsigned B_VALID = 7;
  localparam int unsigned B_IRQ   = 6;
  localparam int unsigned B_JAB   = 5;
  localparam int unsigned B_UND   = 4;
  localparam int unsigned B_MAXC  = 3;
  localparam int unsigned B_OVF   = 2;

  typedef struct packed {
    logic irq;
    logic jab;
    logic und;
    logic maxc;
    logic ovf;
  } txs_ent_t;

  function automatic logic [7:0] ent_to_byte(input logic vld, input txs_ent_t e);
    logic [7:0] b;
    b          = 8'h00;
    b[B_VALID] = vld;
    b[B_IRQ]   = vld & e.irq;
    b[B_JAB]   = vld & e.jab;
    b[B_UND]   = vld & e.und;
    b[B_MAXC]  = vld & e.maxc;
    b[B_OVF]   = vld & e.ovf;
    return b;
  endfunction

endpackage

// File: rtl/txs_store.sv
module txs_store
  import txs_pkg::*;
#(
  parameter int unsigned DEPTH = 4
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     clr,
  input  logic     push,
  input  txs_ent_t push_ent,
  input  logic     pop,
  output txs_ent_t head_ent,
  output logic     not_empty
);

  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [PTR_W-1:0] rd_q, rd_d, wr_q, wr_d, newest;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             full, pop_ok, store, mark;
  txs_ent_t         ent_q [DEPTH];
  txs_ent_t         ent_d [DEPTH];
  logic [DEPTH-1:0] ent_en;

  assign full   = (cnt_q == FULL);
  assign pop_ok = pop && (cnt_q != '0);
  assign store  = push && (!full || pop_ok);
  assign mark   = push && full && !pop_ok;
  assign newest = (wr_q == '0) ? LAST : (wr_q - 1'b1);

  // Pointer and occupancy next state
  always_comb begin
    rd_d  = rd_q;
    wr_d  = wr_q;
    cnt_d = cnt_q;
    if (clr) begin
      rd_d  = '0;
      wr_d  = '0;
      cnt_d = '0;
    end else begin
      if (pop_ok) rd_d = (rd_q == LAST) ? '0 : (rd_q + 1'b1);
      if (store)  wr_d = (wr_q == LAST) ? '0 : (wr_q + 1'b1);
      case ({store, pop_ok})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      rd_q  <= rd_d;
      wr_q  <= wr_d;
      cnt_q <= cnt_d;
    end
  end

  // One slot per entry, written on store or on overflow marking
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_comb begin
      ent_en[i] = 1'b0;
      ent_d[i]  = ent_q[i];
      if (!clr && store && (wr_q == PTR_W'(i))) begin
        ent_en[i] = 1'b1;
        ent_d[i]  = push_ent;
      end else if (!clr && mark && (newest == PTR_W'(i))) begin
        ent_en[i]    = 1'b1;
        ent_d[i].ovf = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         ent_q[i] <= '0;
      else if (ent_en[i]) ent_q[i] <= ent_d[i];
    end
  end

  assign head_ent  = ent_q[rd_q];
  assign not_empty = (cnt_q != '0);

  assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL);
  assert_full_push_keeps_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !clr) |=> (cnt_q == FULL));
  assert_empty_pop_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((cnt_q == '0) && pop && !push && !clr) |=> (cnt_q == '0));
  assert_push_pop_balance_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop && (cnt_q != '0) && !clr) |=> $stable(cnt_q));
  assert_clear_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));

endmodule

// File: rtl/txs_stall.sv
module txs_stall (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic set,
  output logic stall
);

  logic stall_q, stall_d;

  always_comb begin
    stall_d = stall_q;
    if (clr)      stall_d = 1'b0;
    else if (set) stall_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stall_q <= 1'b0;
    else        stall_q <= stall_d;
  end

  assign stall = stall_q;

  assert_stall_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (set && !clr) |=> stall);
  assert_stall_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !clr) |=> stall);
  assert_stall_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !stall);

endmodule

// File: rtl/txs_view.sv
module txs_view
  import txs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  txs_ent_t   head_ent,
  input  logic       head_vld,
  output logic [7:0] rd_data,
  output logic       evt
);

  logic [7:0] byte_w;

  assign byte_w  = ent_to_byte(head_vld, head_ent);
  assign rd_data = byte_w;
  assign evt     = head_vld &
                   (head_ent.irq | head_ent.jab | head_ent.und |
                    head_ent.maxc | head_ent.ovf);

  assert_event_needs_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    evt |-> rd_data[B_VALID]);
  assert_empty_reads_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[B_VALID] |-> (rd_data == 8'h00));
  assert_low_bits_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[1:0] == 2'b00);

endmodule

// File: rtl/txs_stack.sv
module txs_stack
  import txs_pkg::*;
#(
  parameter int unsigned DEPTH = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fin_push_i,
  input  logic       fin_irq_req_i,
  input  logic       fin_jabber_i,
  input  logic       fin_underrun_i,
  input  logic       fin_maxcoll_i,
  input  logic       host_wr_i,
  output logic [7:0] host_rd_data_o,
  output logic       txdone_evt_o,
  input  logic       tx_reset_i,
  output logic       tx_stall_o
);

  txs_ent_t new_ent, head_ent;
  logic     head_vld, stall_set;

  always_comb begin
    new_ent      = '0;
    new_ent.irq  = fin_irq_req_i;
    new_ent.jab  = fin_jabber_i;
    new_ent.und  = fin_underrun_i;
    new_ent.maxc = fin_maxcoll_i;
    new_ent.ovf  = 1'b0;
  end

  assign stall_set = fin_push_i & (fin_jabber_i | fin_underrun_i);

  txs_store #(.DEPTH(DEPTH)) i_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (tx_reset_i),
    .push      (fin_push_i),
    .push_ent  (new_ent),
    .pop       (host_wr_i),
    .head_ent  (head_ent),
    .not_empty (head_vld)
  );

  txs_stall i_stall (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (tx_reset_i),
    .set   (stall_set),
    .stall (tx_stall_o)
  );

  txs_view i_view (
    .clk      (clk),
    .rst_n    (rst_n),
    .head_ent (head_ent),
    .head_vld (head_vld),
    .rd_data  (host_rd_data_o),
    .evt      (txdone_evt_o)
  );

  assert_reset_clears_port_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_reset_i |=> (host_rd_data_o == 8'h00 && !txdone_evt_o && !tx_stall_o));
  assert_first_push_visible_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fin_push_i && !tx_reset_i && !head_vld) |=> host_rd_data_o[B_VALID]);

endmodule

// File: tb/test_txs_stack.sv
`timescale 1ns/1ps
module test_txs_stack;

  localparam int DEPTH = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       push, irq, jab, und, mc, wr, trst;
  logic [7:0] rd;
  logic       evt, stall;

  int checks = 0;
  int fails  = 0;
  logic [7:0] mq[$];
  logic       m_stall = 1'b0;

  always #4 clk = ~clk;

  txs_stack #(.DEPTH(DEPTH)) i_txs_stack (
    .clk            (clk),
    .rst_n          (rst_n),
    .fin_push_i     (push),
    .fin_irq_req_i  (irq),
    .fin_jabber_i   (jab),
    .fin_underrun_i (und),
    .fin_maxcoll_i  (mc),
    .host_wr_i      (wr),
    .host_rd_data_o (rd),
    .txdone_evt_o   (evt),
    .tx_reset_i     (trst),
    .tx_stall_o     (stall)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: compare port against scoreboard front
  task automatic compare(input string req);
    logic [7:0] e;
    logic       ee;
    e  = (mq.size() > 0) ? mq[0] : 8'h00;
    ee = e[7] & (|e[6:2]);
    chk(rd == e, req, rd, e);
    chk(evt == ee, {req, "/R8 evt"}, evt, ee);
    chk(stall == m_stall, {req, "/R6 stall"}, stall, m_stall);
  endtask

  // Driver: one clock of stimulus, starting and ending at a falling edge
  task automatic step(input logic p, input logic [3:0] f, input logic w, input logic r);
    push = p; irq = f[3]; jab = f[2]; und = f[1]; mc = f[0]; wr = w; trst = r;
    if (r) begin
      mq.delete();
      m_stall = 1'b0;
    end else begin
      if (w && mq.size() > 0) void'(mq.pop_front());
      if (p) begin
        if (mq.size() < DEPTH) mq.push_back({1'b1, f, 3'b000});
        else mq[mq.size()-1] = mq[mq.size()-1] | 8'h04;
        if (f[2] | f[1]) m_stall = 1'b1;
      end
    end
    @(negedge clk);
    push = 0; irq = 0; jab = 0; und = 0; mc = 0; wr = 0; trst = 0;
  endtask

  task automatic pop_check(input string req);
    compare(req);
    step(1'b0, 4'h0, 1'b1, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    push = 0; irq = 0; jab = 0; und = 0; mc = 0; wr = 0; trst = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1 reset");

    // R2: single entry with interrupt request
    step(1'b1, 4'b1000, 1'b0, 1'b0);
    chk(rd == 8'hC0, "R2 irq entry", rd, 8'hC0);
    compare("R2");
    pop_check("R3 pop single");
    compare("R4 empty after pop");

    // R3: order across several entries
    step(1'b1, 4'b0001, 1'b0, 1'b0);
    step(1'b1, 4'b0000, 1'b0, 1'b0);
    step(1'b1, 4'b1001, 1'b0, 1'b0);
    chk(rd == 8'h88, "R3 oldest first", rd, 8'h88);
    pop_check("R3 order 1");
    chk(rd == 8'h80 && !evt, "R8 plain entry no event", rd, 8'h80);
    pop_check("R3 order 2");
    pop_check("R3 order 3");
    compare("R4 drained");

    // R4: write to empty stack is ignored
    step(1'b0, 4'h0, 1'b1, 1'b0);
    compare("R4 empty write");
    step(1'b1, 4'b0001, 1'b0, 1'b0);
    chk(rd == 8'h88, "R4 push after ignored write", rd, 8'h88);
    pop_check("R4");

    // R5: overflow marks newest entry
    for (int i = 0; i < DEPTH; i++) step(1'b1, 4'b0000, 1'b0, 1'b0);
    step(1'b1, 4'b1000, 1'b0, 1'b0);
    step(1'b1, 4'b0001, 1'b0, 1'b0);
    for (int i = 0; i < DEPTH - 1; i++) pop_check("R5 drain");
    chk(rd == 8'h84, "R5 overflow bit on newest", rd, 8'h84);
    pop_check("R5 last");
    compare("R5 no extra entry");

    // R9: push and pop same cycle on a full stack
    for (int i = 0; i < DEPTH; i++) step(1'b1, 4'b0000, 1'b0, 1'b0);
    step(1'b1, 4'b1000, 1'b1, 1'b0);
    for (int i = 0; i < DEPTH - 1; i++) pop_check("R9 full drain");
    chk(rd == 8'hC0, "R9 full push+pop stored, no overflow", rd, 8'hC0);
    pop_check("R9 last");
    compare("R9 empty");

    // R9: push and pop same cycle on an empty stack
    step(1'b1, 4'b0001, 1'b1, 1'b0);
    chk(rd == 8'h88, "R9 empty push+pop stored", rd, 8'h88);
    pop_check("R9 empty case");

    // R6/R7: stall from jabber, hold, release by reset
    step(1'b1, 4'b0100, 1'b0, 1'b0);
    chk(stall == 1'b1, "R6 jabber stall", stall, 1);
    chk(rd == 8'hA0, "R2 jabber bit", rd, 8'hA0);
    pop_check("R6 pop keeps stall");
    repeat (3) @(negedge clk);
    chk(stall == 1'b1, "R6 stall held", stall, 1);
    step(1'b1, 4'b0000, 1'b0, 1'b0);
    step(1'b0, 4'h0, 1'b0, 1'b1);
    chk(stall == 1'b0 && rd == 8'h00, "R7 reset clears", {stall, rd}, 0);
    compare("R7");

    // R6: underrun stall; R7: push in the reset cycle is dropped
    step(1'b1, 4'b0010, 1'b0, 1'b0);
    chk(stall == 1'b1 && rd == 8'h90, "R6 underrun stall", {stall, rd}, 9'h190);
    step(1'b1, 4'b1100, 1'b0, 1'b1);
    compare("R7 push with reset dropped");
    chk(rd == 8'h00, "R7 empty after reset", rd, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule